// File: doc/BRIEF.md
# Combining Prefix-Sum Register Unit

This block holds a small bank of shared global registers that many thread control units update at once with an atomic fetch-and-add. Each requester presents a valid strobe, a register index and an increment. One cycle later it gets back the value that register held before its own increment took effect. Requesters never stall, because every request presented in a cycle completes in that cycle.

When several requesters name the same register in the same cycle, the unit combines them in parallel. Port k receives the old register value plus the sum of the increments from all lower-numbered ports that named the same register. The register then advances by the total of all those increments. This gives each requester a distinct slot, which is the building block for parallel queue and array compaction.

A separate set port lets software load a register directly, and a read port lets software inspect one. All arithmetic wraps modulo 2^32.

Top module: `ps_global_regs`

## Requirements
- R1: After reset every register reads 0, and respValid and rdRespValid are low.
- R2: A lone request to register r with increment d returns the old content of r, and r becomes old + d.
- R3: Same-cycle requests to one register are ordered by port index. Port k receives old + the sum of increments from lower-numbered valid ports with the same index, and every valid port gets a response.
- R4: A register's new value is its old value plus the sum of all increments aimed at it in that cycle.
- R5: Requests to different registers in the same cycle do not affect each other's results.
- R6: respValid[k] is high in exactly the cycle after reqValid[k] was high, and low otherwise.
- R7: setValid writes setData into register setIdx. rdValid returns the register's current content on rdRespData one cycle later, with rdRespValid high.
- R8: When a set and prefix-sum requests hit the same register in one cycle, the register takes setData. The prefix-sum responses are computed from the value the register held before the set.
- R9: Results and register updates wrap modulo 2^32.
- R10: A read and a set to the same register in one cycle return the value from before the set.
- R11: A register named by no request and no set keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 8 | Per-port prefix-sum request strobe |
| reqIdx | input | 8x3 | Per-port target register index |
| reqInc | input | 8x32 | Per-port increment |
| respValid | output | 8 | Per-port response valid, one cycle after the request |
| respData | output | 8x32 | Per-port pre-increment value (with lower-port prefix) |
| setValid | input | 1 | Direct write strobe |
| setIdx | input | 3 | Register to write |
| setData | input | 32 | Value to write |
| rdValid | input | 1 | Read strobe |
| rdIdx | input | 3 | Register to read |
| rdRespValid | output | 1 | Read result valid |
| rdRespData | output | 32 | Read result |

## Verification
The bench uses the default build: 8 ports, 8 registers and 32-bit values. In about a third of the random cycles the register index is limited to two values, so collisions of up to eight ports on one register occur often and the whole prefix chain is exercised. The full 32-bit width lets directed cases preset a register near its maximum, which brings wrap-around of both the responses and the register update within reach.

// File: rtl/ps_regs_pkg.sv
package ps_regs_pkg;
  localparam int PS_PORTS = 8;
  localparam int PS_REGS  = 8;
  localparam int PS_DW    = 32;
  localparam int PS_IW    = (PS_REGS > 1) ? $clog2(PS_REGS) : 1;

  typedef logic [PS_DW-1:0] word_t;
  typedef logic [PS_IW-1:0] idx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [PS_REGS-1:0][PS_PORTS-1:0] psHit;  // register x port match matrix
    logic [PS_PORTS-1:0]              psGo;   // accepted prefix-sum per port
    logic [PS_REGS-1:0]               setGo;  // direct write per register
    logic                             rdGo;   // read strobe
  } ctrl_t;
endpackage

// File: rtl/ps_ctrl.sv
module ps_ctrl
  import ps_regs_pkg::*;
#(
  parameter int NUM_PORTS = PS_PORTS,
  parameter int NUM_REGS  = PS_REGS,
  localparam int IW       = PS_IW
) (
  input  logic [NUM_PORTS-1:0]         reqValid,
  input  logic [NUM_PORTS-1:0][IW-1:0] reqIdx,
  input  logic                         setValid,
  input  logic [IW-1:0]                setIdx,
  input  logic                         rdValid,
  output ctrl_t                        ctrl
);

  always_comb begin
    ctrl = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        ctrl.psHit[r][p] = reqValid[p] && (reqIdx[p] == IW'(r));
      end
      ctrl.setGo[r] = setValid && (setIdx == IW'(r));
    end
    ctrl.psGo = reqValid;
    ctrl.rdGo = rdValid;
  end

endmodule

// File: rtl/ps_datapath.sv
module ps_datapath
  import ps_regs_pkg::*;
#(
  parameter int NUM_PORTS = PS_PORTS,
  parameter int NUM_REGS  = PS_REGS,
  parameter int DW        = PS_DW,
  localparam int IW       = PS_IW
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_t                        ctrl,
  input  logic [NUM_PORTS-1:0][IW-1:0] reqIdx,
  input  logic [NUM_PORTS-1:0][DW-1:0] reqInc,
  input  logic [DW-1:0]                setData,
  input  logic [IW-1:0]                rdIdx,
  output logic [NUM_PORTS-1:0]         respValid,
  output logic [NUM_PORTS-1:0][DW-1:0] respData,
  output logic                         rdRespValid,
  output logic [DW-1:0]                rdRespData
);

  logic [NUM_REGS-1:0][DW-1:0]  regFile;
  logic [NUM_REGS-1:0][DW-1:0]  regTotal;
  logic [NUM_PORTS-1:0][DW-1:0] portPrefix;
  logic [NUM_PORTS-1:0][DW-1:0] portResult;

  // exclusive prefix of same-register increments from lower ports
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_prefix
      always_comb begin
        portPrefix[p] = '0;
        for (int q = 0; q < p; q++) begin
          if (ctrl.psHit[reqIdx[p]][q]) portPrefix[p] = portPrefix[p] + reqInc[q];
        end
        portResult[p] = regFile[reqIdx[p]] + portPrefix[p];
      end
    end
  endgenerate

  // combined increment per register
  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_total
      always_comb begin
        regTotal[r] = '0;
        for (int q = 0; q < NUM_PORTS; q++) begin
          if (ctrl.psHit[r][q]) regTotal[r] = regTotal[r] + reqInc[q];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              regFile[r] <= '0;
        else if (ctrl.setGo[r]) regFile[r] <= setData;
        else                    regFile[r] <= regFile[r] + regTotal[r];
      end

      AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (!ctrl.setGo[r] && (ctrl.psHit[r] == '0)) |=> $stable(regFile[r])); // R11
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.setGo[r] |=> (regFile[r] == $past(setData))); // R8
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid   <= '0;
      respData    <= '0;
      rdRespValid <= 1'b0;
      rdRespData  <= '0;
    end else begin
      respValid   <= ctrl.psGo;
      respData    <= portResult;
      rdRespValid <= ctrl.rdGo;
      rdRespData  <= regFile[rdIdx];
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.psGo[p] |=> respValid[p]); // R6
      AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.psGo[p] |=> !respValid[p]); // R6
      AST_LONE_OLD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.psGo[p] && ($countones(ctrl.psHit[reqIdx[p]]) == 1))
          |=> (respData[p] == $past(regFile[reqIdx[p]]))); // R2
    end
  endgenerate

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rdGo |=> rdRespValid); // R7

endmodule

// File: rtl/ps_global_regs.sv
module ps_global_regs
  import ps_regs_pkg::*;
#(
  parameter int NUM_PORTS = PS_PORTS,
  parameter int NUM_REGS  = PS_REGS,
  parameter int DW        = PS_DW,
  localparam int IW       = PS_IW
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PORTS-1:0]         reqValid,
  input  logic [NUM_PORTS-1:0][IW-1:0] reqIdx,
  input  logic [NUM_PORTS-1:0][DW-1:0] reqInc,
  output logic [NUM_PORTS-1:0]         respValid,
  output logic [NUM_PORTS-1:0][DW-1:0] respData,
  input  logic                         setValid,
  input  logic [IW-1:0]                setIdx,
  input  logic [DW-1:0]                setData,
  input  logic                         rdValid,
  input  logic [IW-1:0]                rdIdx,
  output logic                         rdRespValid,
  output logic [DW-1:0]                rdRespData
);

  ctrl_t ctrl;

  ps_ctrl #(.NUM_PORTS(NUM_PORTS), .NUM_REGS(NUM_REGS)) u_ctrl (
    .reqValid (reqValid),
    .reqIdx   (reqIdx),
    .setValid (setValid),
    .setIdx   (setIdx),
    .rdValid  (rdValid),
    .ctrl     (ctrl)
  );

  ps_datapath #(.NUM_PORTS(NUM_PORTS), .NUM_REGS(NUM_REGS), .DW(DW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqIdx      (reqIdx),
    .reqInc      (reqInc),
    .setData     (setData),
    .rdIdx       (rdIdx),
    .respValid   (respValid),
    .respData    (respData),
    .rdRespValid (rdRespValid),
    .rdRespData  (rdRespData)
  );

endmodule

// File: tb/tb_ps_global_regs.sv
`timescale 1ns/1ps
module tb_ps_global_regs;
  localparam int P  = 8;
  localparam int R  = 8;
  localparam int DW = 32;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [P-1:0]         reqValid = '0;
  logic [P-1:0][IW-1:0] reqIdx   = '0;
  logic [P-1:0][DW-1:0] reqInc   = '0;
  logic [P-1:0]         respValid;
  logic [P-1:0][DW-1:0] respData;
  logic                 setValid = 1'b0;
  logic [IW-1:0]        setIdx   = '0;
  logic [DW-1:0]        setData  = '0;
  logic                 rdValid  = 1'b0;
  logic [IW-1:0]        rdIdx    = '0;
  logic                 rdRespValid;
  logic [DW-1:0]        rdRespData;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model [R];

  always #10 clk = ~clk;

  ps_global_regs dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIdx(reqIdx), .reqInc(reqInc),
    .respValid(respValid), .respData(respData),
    .setValid(setValid), .setIdx(setIdx), .setData(setData),
    .rdValid(rdValid), .rdIdx(rdIdx),
    .rdRespValid(rdRespValid), .rdRespData(rdRespData)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    reqValid = '0; reqIdx = '0; reqInc = '0;
    setValid = 1'b0; setIdx = '0; setData = '0;
    rdValid = 1'b0; rdIdx = '0;
  endtask

  // one cycle: expected from model, clock, compare, advance model
  task automatic step(input string tag);
    logic [DW-1:0] expResp [P];
    logic [DW-1:0] expRd;
    logic [DW-1:0] nxt [R];
    for (int p = 0; p < P; p++) begin
      logic [DW-1:0] acc;
      acc = model[reqIdx[p]];
      for (int q = 0; q < p; q++)
        if (reqValid[q] && reqIdx[q] == reqIdx[p]) acc = acc + reqInc[q];
      expResp[p] = acc;
    end
    expRd = model[rdIdx];
    for (int r = 0; r < R; r++) begin
      nxt[r] = model[r];
      for (int q = 0; q < P; q++)
        if (reqValid[q] && reqIdx[q] == IW'(r)) nxt[r] = nxt[r] + reqInc[q];
      if (setValid && setIdx == IW'(r)) nxt[r] = setData;
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < P; p++) begin
      chk({tag, " R6 valid"}, DW'(respValid[p]), DW'(reqValid[p]));
      if (reqValid[p]) chk({tag, " R3 data"}, respData[p], expResp[p]);
    end
    chk({tag, " R7 rdValid"}, DW'(rdRespValid), DW'(rdValid));
    if (rdValid) chk({tag, " R7 rdData"}, rdRespData, expRd);
    for (int r = 0; r < R; r++) model[r] = nxt[r];
  endtask

  task automatic readReg(input int r, input string tag);
    clearIn();
    rdValid = 1'b1; rdIdx = IW'(r);
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < R; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    chk("R1 resp idle in reset", DW'(respValid), '0);
    chk("R1 read idle in reset", DW'(rdRespValid), '0);
    rstN = 1'b1;
    @(negedge clk);
    for (int r = 0; r < R; r++) begin
      readReg(r, "R1 reset value");
      chk("R1 reset zero", rdRespData, '0);
    end

    // R2: lone request
    clearIn();
    reqValid[3] = 1'b1; reqIdx[3] = 3'd4; reqInc[3] = 32'd7;
    step("R2 lone");
    chk("R2 lone old", respData[3], 32'd0);
    clearIn();
    reqValid[0] = 1'b1; reqIdx[0] = 3'd4; reqInc[0] = 32'd5;
    step("R2 lone second");
    chk("R2 sees prior increment", respData[0], 32'd7);

    // R3/R4: all ports on register 2, increments p+1
    clearIn();
    for (int p = 0; p < P; p++) begin
      reqValid[p] = 1'b1; reqIdx[p] = 3'd2; reqInc[p] = DW'(p + 1);
    end
    step("R3 eight-way");
    for (int p = 0; p < P; p++) chk("R3 prefix", respData[p], DW'(p * (p + 1) / 2));
    readReg(2, "R4 total");
    chk("R4 total 36", rdRespData, 32'd36);

    // R5: distinct registers
    clearIn();
    for (int p = 0; p < P; p++) begin
      reqValid[p] = 1'b1; reqIdx[p] = IW'(p); reqInc[p] = DW'(100 + p);
    end
    step("R5 distinct");
    chk("R5 reg2 result", respData[2], 32'd36);
    chk("R5 reg4 result", respData[4], 32'd12);

    // R7: set then read
    clearIn();
    setValid = 1'b1; setIdx = 3'd6; setData = 32'hCAFE_0001;
    step("R7 set");
    readReg(6, "R7 read");
    chk("R7 read set value", rdRespData, 32'hCAFE_0001);

    // R8: set vs prefix-sum on same register
    clearIn();
    setValid = 1'b1; setIdx = 3'd6; setData = 32'h0000_1000;
    reqValid[1] = 1'b1; reqIdx[1] = 3'd6; reqInc[1] = 32'd3;
    reqValid[5] = 1'b1; reqIdx[5] = 3'd6; reqInc[5] = 32'd4;
    step("R8 set priority");
    chk("R8 port1 pre-set", respData[1], 32'hCAFE_0001);
    chk("R8 port5 pre-set", respData[5], 32'hCAFE_0004);
    readReg(6, "R8 set kept");
    chk("R8 register holds set", rdRespData, 32'h0000_1000);

    // R9: wrap
    clearIn();
    setValid = 1'b1; setIdx = 3'd5; setData = 32'hFFFF_FFF0;
    step("R9 preset");
    clearIn();
    reqValid[0] = 1'b1; reqIdx[0] = 3'd5; reqInc[0] = 32'h10;
    reqValid[7] = 1'b1; reqIdx[7] = 3'd5; reqInc[7] = 32'h10;
    step("R9 wrap");
    chk("R9 port0", respData[0], 32'hFFFF_FFF0);
    chk("R9 port7 wrapped", respData[7], 32'h0);
    readReg(5, "R9 reg");
    chk("R9 reg wrapped", rdRespData, 32'h10);

    // R10: read and set same register
    clearIn();
    setValid = 1'b1; setIdx = 3'd1; setData = 32'hABCD;
    rdValid = 1'b1; rdIdx = 3'd1;
    step("R10 read-set");
    chk("R10 pre-set read", rdRespData, 32'd101);

    // R11: idle cycle keeps values
    clearIn();
    step("R11 idle");
    chk("R11 no response", DW'(respValid), '0);
    for (int r = 0; r < R; r++) readReg(r, "R11 hold");

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit narrow;
      clearIn();
      narrow = ($urandom_range(0, 2) == 0);
      for (int p = 0; p < P; p++) begin
        reqValid[p] = ($urandom_range(0, 3) != 0);
        reqIdx[p]   = narrow ? IW'($urandom_range(0, 1)) : IW'($urandom_range(0, R - 1));
        reqInc[p]   = ($urandom_range(0, 3) == 0) ? DW'($urandom) : DW'($urandom_range(0, 15));
      end
      setValid = ($urandom_range(0, 7) == 0);
      setIdx   = IW'($urandom_range(0, R - 1));
      setData  = DW'($urandom);
      rdValid  = ($urandom_range(0, 1) == 1);
      rdIdx    = IW'($urandom_range(0, R - 1));
      step("R3 R4 R5 R8 random");
    end
    for (int r = 0; r < R; r++) readReg(r, "R4 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule